// File: doc/BRIEF.md
# NAND Flash Operation Engine

This block runs one NAND bus operation each time software triggers it. Software loads a command byte or an address byte into a holding register, or picks one of several internal page buffers. It then writes a control word in which a single bit names the operation: command latch, address latch, data input to the flash, page data output from the flash, device ID read or status read. The engine drives CLE, ALE, CE#, WE#, RE# and the 8-bit data bus with fixed strobe timing. It then waits for the ready/busy input to come high, sets a sticky done flag and raises a level interrupt unless the interrupt is masked.

Each buffer has a main area of `MAIN_BYTES` and a spare area of `SPARE_BYTES`. All main areas sit first in the buffer address space, followed by all spare areas. A data-input transfer streams the main area and then the spare area of the selected buffer. A page-output transfer fills them in the same order. A driver builds a full flash command sequence from these single steps, for example command, several address cycles, a second command, then page output. Because the engine follows ready/busy itself, the driver only waits for done or the interrupt.

Top module: `nand_op_engine`

## Requirements
- R1: A control write whose bits 5:0 are 000001 gives exactly one WE# low pulse. During the pulse CLE is high, ALE is low, and the bus carries the byte that was in the command register when the operation was triggered.
- R2: Control bits 5:0 equal to 000010 give one WE# pulse with ALE high and CLE low. The bus carries the address register byte.
- R3: Control bits 5:0 equal to 000100 give MAIN_BYTES+SPARE_BYTES WE# pulses with CLE and ALE low. They send the selected buffer's main bytes in ascending order, then its spare bytes in ascending order.
- R4: Control bits 5:0 equal to 001000 (output field 001) give MAIN_BYTES+SPARE_BYTES RE# pulses. Byte k read from the flash is stored at buffer address n·MAIN_BYTES+k when k<MAIN_BYTES, and at NUM_BUFS·MAIN_BYTES + n·SPARE_BYTES + (k−MAIN_BYTES) otherwise, where n is the buffer-select value. Other buffers keep their contents.
- R5: Control bits 5:0 equal to 010000 give ID_BYTES RE# pulses into main bytes 0..ID_BYTES−1 of the selected buffer. The rest of that main area is unchanged.
- R6: Control bits 5:0 equal to 100000 give one RE# pulse whose byte lands in main byte 0 of the selected buffer. Byte 1 is unchanged.
- R7: Control bit 15 is the done flag. It becomes 1 on the same clock edge on which the engine leaves the busy state. It then stays 1 until a control write with bit 15 at 0 clears it. A control write with bit 15 at 1 leaves it set.
- R8: The interrupt output is high exactly when done is 1 and the mask bit (configuration bit 4) is 0.
- R9: Status bit 0 reads 1 while an operation runs, and control bits 5:0 read back the running selection. A trigger written while busy starts nothing.
- R10: After its last strobe, an operation does not complete until the ready/busy input is high.
- R11: If ready/busy stays low for more than the timeout register value in clock cycles, the operation completes anyway and status bit 1 reads 1. Status bit 1 returns to 0 when the next operation starts.
- R12: Each WE# or RE# pulse is low for T_LOW cycles and then high for T_HIGH cycles. With ready/busy already high, CE# is low for pulses·(T_LOW+T_HIGH)+1 cycles.
- R13: A control word whose bits 5:0 are zero or have more than one bit set starts no operation.
- R14: The top address bit selects the register window. There, offsets 0 to 6 are command, address, buffer select, configuration, control, status and timeout. With the top address bit at 0, the address picks a buffer byte, carried on data bits 7:0. After reset, control and status read 0, the interrupt is low, and CE#, WE# and RE# are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostAddr | input | ADDR_W | Register or buffer byte address |
| hostWe | input | 1 | Write strobe for the host port |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data (combinational) |
| irq | output | 1 | Level interrupt |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandCeN | output | 1 | Chip enable, active low |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDout | output | 8 | Data toward the flash |
| nandDoe | output | 1 | Output enable for nandDout |
| nandDin | input | 8 | Data from the flash |
| nandRdy | input | 1 | Ready/busy, high when ready |

## Verification
Command and address latches are swept over several byte values. A byte stuck at the wrong register, or a swapped CLE/ALE, shows up as a mismatch there. Data input and page output run through both buffers of a reduced configuration, with contents computed from the byte index. This tells a wrong main/spare base, a wrong byte order or a write that leaks into the other buffer apart from a correct one. ID and status reads are checked against their neighbouring bytes, which must keep the older page data. Strobe widths and CE# duration are counted per operation, and ready/busy is held low to separate waiting, timeout and the error flag.

// File: rtl/nand_eng_pkg.sv
package nand_eng_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CMD,
    OP_ADDR,
    OP_DIN,
    OP_PAGE,
    OP_ID,
    OP_STAT
  } opKind_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic start;     // trigger accepted this cycle
    logic capture;   // sample nandDin into the buffer this cycle
    logic finish;    // operation completes this cycle
    logic timedOut;  // completion is due to the ready timeout
  } engStrobe_t;

  localparam logic [2:0] OFF_CMD  = 3'd0;
  localparam logic [2:0] OFF_ADDR = 3'd1;
  localparam logic [2:0] OFF_BUF  = 3'd2;
  localparam logic [2:0] OFF_CFG  = 3'd3;
  localparam logic [2:0] OFF_CTRL = 3'd4;
  localparam logic [2:0] OFF_STAT = 3'd5;
  localparam logic [2:0] OFF_TMO  = 3'd6;

endpackage

// File: rtl/nand_eng_ctrl.sv
module nand_eng_ctrl
  import nand_eng_pkg::*;
#(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int ID_BYTES    = 5,
  parameter int T_LOW       = 2,
  parameter int T_HIGH      = 2,
  parameter int TMO_W       = 16,
  parameter int IDX_W       = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigValid,
  input  opKind_t          trigOp,
  input  logic             nandRdy,
  input  logic [TMO_W-1:0] tmoLimit,
  output engStrobe_t       strobe,
  output logic [IDX_W-1:0] byteIdx,
  output opKind_t          curOp,
  output logic             busy,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandCeN,
  output logic             nandWeN,
  output logic             nandReN
);

  localparam int PH_MAX = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_WAIT} seqState_t;

  seqState_t        state;
  logic [PH_W-1:0]  phaseCnt;
  logic [TMO_W-1:0] tmoCnt;
  logic [IDX_W-1:0] lastIdx;
  logic             isRead;
  logic             isWrite;
  logic             loEnd;
  logic             hiEnd;
  logic             expired;

  assign isRead  = (curOp == OP_PAGE) || (curOp == OP_ID) || (curOp == OP_STAT);
  assign isWrite = (curOp == OP_CMD) || (curOp == OP_ADDR) || (curOp == OP_DIN);
  assign loEnd   = (state == S_LO) && (phaseCnt == PH_W'(T_LOW - 1));
  assign hiEnd   = (state == S_HI) && (phaseCnt == PH_W'(T_HIGH - 1));
  assign expired = !nandRdy && (tmoCnt >= tmoLimit);

  always_comb begin
    case (curOp)
      OP_DIN, OP_PAGE: lastIdx = IDX_W'(MAIN_BYTES + SPARE_BYTES - 1);
      OP_ID:           lastIdx = IDX_W'(ID_BYTES - 1);
      default:         lastIdx = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      phaseCnt <= '0;
      tmoCnt   <= '0;
      byteIdx  <= '0;
      curOp    <= OP_NONE;
    end else begin
      case (state)
        S_IDLE: begin
          if (trigValid) begin
            curOp    <= trigOp;
            byteIdx  <= '0;
            phaseCnt <= '0;
            state    <= S_LO;
          end
        end
        S_LO: begin
          if (loEnd) begin
            phaseCnt <= '0;
            state    <= S_HI;
          end else begin
            phaseCnt <= phaseCnt + PH_W'(1);
          end
        end
        S_HI: begin
          if (hiEnd) begin
            phaseCnt <= '0;
            if (byteIdx == lastIdx) begin
              tmoCnt <= '0;
              state  <= S_WAIT;
            end else begin
              byteIdx <= byteIdx + IDX_W'(1);
              state   <= S_LO;
            end
          end else begin
            phaseCnt <= phaseCnt + PH_W'(1);
          end
        end
        default: begin
          if (nandRdy || expired) begin
            state <= S_IDLE;
            curOp <= OP_NONE;
          end else begin
            tmoCnt <= tmoCnt + TMO_W'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.start    = (state == S_IDLE) && trigValid;
    strobe.capture  = loEnd && isRead;
    strobe.finish   = (state == S_WAIT) && (nandRdy || expired);
    strobe.timedOut = (state == S_WAIT) && expired;
  end

  assign busy    = (state != S_IDLE);
  assign nandCeN = (state == S_IDLE);
  assign nandWeN = !((state == S_LO) && isWrite);
  assign nandReN = !((state == S_LO) && isRead);
  assign nandCle = ((state == S_LO) || (state == S_HI)) && (curOp == OP_CMD);
  assign nandAle = ((state == S_LO) || (state == S_HI)) && (curOp == OP_ADDR);

endmodule

// File: rtl/nand_eng_dp.sv
module nand_eng_dp
  import nand_eng_pkg::*;
#(
  parameter int NUM_BUFS    = 4,
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int TMO_W       = 16,
  parameter int IDX_W       = 10,
  parameter int MEM_AW      = 12,
  parameter int ADDR_W      = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWe,
  input  logic [15:0]       hostWdata,
  output logic [15:0]       hostRdata,
  input  logic [7:0]        nandDin,
  input  engStrobe_t        strobe,
  input  logic [IDX_W-1:0]  byteIdx,
  input  opKind_t           curOp,
  input  logic              busy,
  output logic              trigValid,
  output opKind_t           trigOp,
  output logic [TMO_W-1:0]  tmoLimit,
  output logic [7:0]        nandDout,
  output logic              nandDoe,
  output logic              irq,
  output logic              doneFlag,
  output logic              intMask
);

  localparam int TOTAL = NUM_BUFS * (MAIN_BYTES + SPARE_BYTES);
  localparam int BUF_W = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1;

  logic [7:0]        mem [TOTAL];
  logic [7:0]        cmdReg;
  logic [7:0]        addrReg;
  logic [BUF_W-1:0]  bufSelReg;
  logic [BUF_W-1:0]  opBuf;
  logic [7:0]        opByte;
  logic [5:0]        opBits;
  logic              errFlag;
  logic              regHit;
  logic [2:0]        regOff;
  logic [MEM_AW-1:0] hostIdx;
  logic              hostInRange;
  logic [MEM_AW-1:0] engAddr;
  logic              ctrlWr;

  assign regHit      = hostAddr[ADDR_W-1] && (hostAddr[ADDR_W-2:3] == '0);
  assign regOff      = hostAddr[2:0];
  assign hostIdx     = hostAddr[MEM_AW-1:0];
  assign hostInRange = !hostAddr[ADDR_W-1] && (int'(hostIdx) < TOTAL);
  assign ctrlWr      = hostWe && regHit && (regOff == OFF_CTRL);

  always_comb begin
    case (hostWdata[5:0])
      6'b000001: trigOp = OP_CMD;
      6'b000010: trigOp = OP_ADDR;
      6'b000100: trigOp = OP_DIN;
      6'b001000: trigOp = OP_PAGE;
      6'b010000: trigOp = OP_ID;
      6'b100000: trigOp = OP_STAT;
      default:   trigOp = OP_NONE;
    endcase
  end

  assign trigValid = ctrlWr && (trigOp != OP_NONE) && !busy;

  // Buffer byte touched by the transfer in flight
  always_comb begin
    int base;
    if (int'(byteIdx) < MAIN_BYTES)
      base = int'(opBuf) * MAIN_BYTES + int'(byteIdx);
    else
      base = NUM_BUFS * MAIN_BYTES + int'(opBuf) * SPARE_BYTES + int'(byteIdx) - MAIN_BYTES;
    engAddr = MEM_AW'(base);
  end

  always_ff @(posedge clk) begin
    if (strobe.capture)
      mem[engAddr] <= nandDin;
    else if (hostWe && hostInRange)
      mem[hostIdx] <= hostWdata[7:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg    <= '0;
      addrReg   <= '0;
      bufSelReg <= '0;
      intMask   <= 1'b0;
      tmoLimit  <= '1;
      doneFlag  <= 1'b0;
      errFlag   <= 1'b0;
      opByte    <= '0;
      opBuf     <= '0;
      opBits    <= '0;
    end else begin
      if (hostWe && regHit) begin
        case (regOff)
          OFF_CMD:  cmdReg    <= hostWdata[7:0];
          OFF_ADDR: addrReg   <= hostWdata[7:0];
          OFF_BUF:  bufSelReg <= hostWdata[BUF_W-1:0];
          OFF_CFG:  intMask   <= hostWdata[4];
          OFF_TMO:  tmoLimit  <= TMO_W'(hostWdata);
          default: ;
        endcase
      end
      if (ctrlWr && !hostWdata[15])
        doneFlag <= 1'b0;
      if (strobe.start) begin
        opByte  <= (trigOp == OP_CMD) ? cmdReg : addrReg;
        opBuf   <= bufSelReg;
        opBits  <= hostWdata[5:0];
        errFlag <= 1'b0;
      end
      if (strobe.finish) begin
        doneFlag <= 1'b1;
        opBits   <= '0;
        if (strobe.timedOut)
          errFlag <= 1'b1;
      end
    end
  end

  always_comb begin
    hostRdata = '0;
    if (regHit) begin
      case (regOff)
        OFF_CMD:  hostRdata = {8'h00, cmdReg};
        OFF_ADDR: hostRdata = {8'h00, addrReg};
        OFF_BUF:  hostRdata = 16'(bufSelReg);
        OFF_CFG:  hostRdata = {11'b0, intMask, 4'b0};
        OFF_CTRL: hostRdata = {doneFlag, 9'b0, opBits};
        OFF_STAT: hostRdata = {14'b0, errFlag, busy};
        OFF_TMO:  hostRdata = 16'(tmoLimit);
        default:  hostRdata = '0;
      endcase
    end else if (hostInRange) begin
      hostRdata = {8'h00, mem[hostIdx]};
    end
  end

  always_comb begin
    case (curOp)
      OP_CMD, OP_ADDR: nandDout = opByte;
      OP_DIN:          nandDout = mem[engAddr];
      default:         nandDout = '0;
    endcase
  end

  assign nandDoe = (curOp == OP_CMD) || (curOp == OP_ADDR) || (curOp == OP_DIN);
  assign irq     = doneFlag && !intMask;

endmodule

// File: rtl/nand_op_engine.sv
module nand_op_engine
  import nand_eng_pkg::*;
#(
  parameter int NUM_BUFS    = 4,
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int ID_BYTES    = 5,
  parameter int T_LOW       = 2,
  parameter int T_HIGH      = 2,
  parameter int TMO_W       = 16,
  localparam int TOTAL      = NUM_BUFS * (MAIN_BYTES + SPARE_BYTES),
  localparam int MEM_AW     = $clog2(TOTAL),
  localparam int ADDR_W     = MEM_AW + 1,
  localparam int IDX_W      = $clog2(MAIN_BYTES + SPARE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWe,
  input  logic [15:0]       hostWdata,
  output logic [15:0]       hostRdata,
  output logic              irq,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandCeN,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [7:0]        nandDout,
  output logic              nandDoe,
  input  logic [7:0]        nandDin,
  input  logic              nandRdy
);

  engStrobe_t       strobe;
  logic [IDX_W-1:0] byteIdx;
  opKind_t          curOp;
  opKind_t          trigOp;
  logic             trigValid;
  logic             busy;
  logic [TMO_W-1:0] tmoLimit;
  logic             doneFlag;
  logic             intMask;

  nand_eng_ctrl #(
    .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES), .ID_BYTES(ID_BYTES),
    .T_LOW(T_LOW), .T_HIGH(T_HIGH), .TMO_W(TMO_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .trigValid(trigValid), .trigOp(trigOp),
    .nandRdy(nandRdy), .tmoLimit(tmoLimit), .strobe(strobe), .byteIdx(byteIdx),
    .curOp(curOp), .busy(busy), .nandCle(nandCle), .nandAle(nandAle),
    .nandCeN(nandCeN), .nandWeN(nandWeN), .nandReN(nandReN)
  );

  nand_eng_dp #(
    .NUM_BUFS(NUM_BUFS), .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES),
    .TMO_W(TMO_W), .IDX_W(IDX_W), .MEM_AW(MEM_AW), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWe(hostWe),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .nandDin(nandDin),
    .strobe(strobe), .byteIdx(byteIdx), .curOp(curOp), .busy(busy),
    .trigValid(trigValid), .trigOp(trigOp), .tmoLimit(tmoLimit),
    .nandDout(nandDout), .nandDoe(nandDoe), .irq(irq),
    .doneFlag(doneFlag), .intMask(intMask)
  );

endmodule

// File: rtl/nand_op_engine_chk.sv
module nand_op_engine_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              hostWe,
  input logic [15:0]       hostWdata,
  input logic              irq,
  input logic              nandCle,
  input logic              nandAle,
  input logic              nandCeN,
  input logic              nandWeN,
  input logic              nandReN,
  input logic              nandDoe,
  input logic              doneFlag,
  input logic              intMask,
  input logic              busy
);

  logic doneClearWr;
  assign doneClearWr = hostWe && hostAddr[ADDR_W-1] && (hostAddr[ADDR_W-2:3] == '0)
                       && (hostAddr[2:0] == 3'd4) && !hostWdata[15];

  assert_cle_ale_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  assert_drive_on_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |-> nandDoe);

  assert_no_drive_on_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandDoe);

  assert_done_on_completion_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneFlag);

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !doneClearWr) |=> doneFlag);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    intMask |-> !irq);

  assert_irq_needs_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> doneFlag);

  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  assert_ce_with_strobe_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN || !nandReN) |-> !nandCeN);

endmodule

bind nand_op_engine nand_op_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWe(hostWe),
  .hostWdata(hostWdata), .irq(irq), .nandCle(nandCle), .nandAle(nandAle),
  .nandCeN(nandCeN), .nandWeN(nandWeN), .nandReN(nandReN), .nandDoe(nandDoe),
  .doneFlag(doneFlag), .intMask(intMask), .busy(busy)
);

// File: tb/nand_op_engine_bench.sv
`timescale 1ns/1ps
module nand_op_engine_bench;

  localparam int NB     = 2;
  localparam int MB     = 8;
  localparam int SB     = 2;
  localparam int IDB    = 4;
  localparam int TL     = 2;
  localparam int TH     = 3;
  localparam int PB     = MB + SB;
  localparam int ADDR_W = $clog2(NB * PB) + 1;
  localparam int RBASE  = 1 << (ADDR_W - 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic              hostWe = 1'b0;
  logic [15:0]       hostWdata = '0;
  logic [15:0]       hostRdata;
  logic              irq, nandCle, nandAle, nandCeN, nandWeN, nandReN, nandDoe;
  logic [7:0]        nandDout, nandDin;
  logic              nandRdy = 1'b1;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // Flash model bookkeeping (cumulative counters)
  int readCount = 0, readBase = 0, seed = 0;
  int logCount = 0, weLow = 0, ceLow = 0;
  int logData [256];
  int logCle  [256];
  int logAle  [256];
  logic prevWe = 1'b1, prevRe = 1'b1;

  assign nandDin = 8'(((readCount - readBase) * 29) + seed);

  always #2 clk = ~clk;

  nand_op_engine #(
    .NUM_BUFS(NB), .MAIN_BYTES(MB), .SPARE_BYTES(SB), .ID_BYTES(IDB),
    .T_LOW(TL), .T_HIGH(TH), .TMO_W(8)
  ) u_nand_op_engine (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWe(hostWe),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .irq(irq),
    .nandCle(nandCle), .nandAle(nandAle), .nandCeN(nandCeN),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandDout(nandDout),
    .nandDoe(nandDoe), .nandDin(nandDin), .nandRdy(nandRdy)
  );

  always @(negedge clk) begin
    if (!prevWe && nandWeN && logCount < 256) begin
      logData[logCount] = int'(nandDout);
      logCle[logCount]  = int'(nandCle);
      logAle[logCount]  = int'(nandAle);
      logCount = logCount + 1;
    end
    if (!prevRe && nandReN) readCount = readCount + 1;
    if (!nandWeN) weLow = weLow + 1;
    if (!nandCeN) ceLow = ceLow + 1;
    prevWe = nandWeN;
    prevRe = nandReN;
  end

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(int a, int d);
    @(negedge clk);
    hostAddr  = ADDR_W'(a);
    hostWdata = 16'(d);
    hostWe    = 1'b1;
    @(negedge clk);
    hostWe    = 1'b0;
  endtask

  task automatic hread(int a, output int d);
    @(negedge clk);
    hostAddr = ADDR_W'(a);
    #1;
    d = int'(hostRdata);
  endtask

  int lb, wb, cb;

  task automatic launch(int bits);
    readBase = readCount;
    lb = logCount;
    wb = weLow;
    cb = ceLow;
    hwrite(RBASE + 4, bits);
  endtask

  task automatic waitIdle();
    int v;
    for (int i = 0; i < 3000; i++) begin
      hread(RBASE + 5, v);
      if ((v & 1) == 0) return;
    end
    chk("R9 engine never idle", 1, 0);
  endtask

  function automatic int mainAddr(int b, int k);
    return b * MB + k;
  endfunction
  function automatic int spareAddr(int b, int j);
    return NB * MB + b * SB + j;
  endfunction
  function automatic int pat(int s, int k);
    return ((k * 29) + s) & 255;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int v;
    int cmdVals [4] = '{8'h00, 8'h5A, 8'hFF, 8'h90};
    int addrVals [2] = '{8'h3C, 8'hC1};
    int seeds [2] = '{8'h11, 8'h42};
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R14: reset state
    hread(RBASE + 4, v); chk("R14 ctrl reset", v, 0);
    hread(RBASE + 5, v); chk("R14 status reset", v, 0);
    chk("R14 irq reset", int'(irq), 0);
    chk("R14 strobes idle", int'({nandCeN, nandWeN, nandReN}), 7);

    // R1 / R12: command latch sweep
    foreach (cmdVals[i]) begin
      hwrite(RBASE + 0, cmdVals[i]);
      launch(6'b000001);
      hwrite(RBASE + 0, 8'h77);   // changing the register after trigger must not matter
      waitIdle();
      chk("R1 one WE pulse", logCount - lb, 1);
      chk("R1 cmd byte", logData[lb], cmdVals[i]);
      chk("R1 CLE high", logCle[lb], 1);
      chk("R1 ALE low", logAle[lb], 0);
      chk("R12 WE low width", weLow - wb, TL);
      chk("R12 CE low cycles", ceLow - cb, TL + TH + 1);
    end

    // R2: address latch sweep
    foreach (addrVals[i]) begin
      hwrite(RBASE + 1, addrVals[i]);
      launch(6'b000010);
      waitIdle();
      chk("R2 one WE pulse", logCount - lb, 1);
      chk("R2 addr byte", logData[lb], addrVals[i]);
      chk("R2 ALE high", logAle[lb], 1);
      chk("R2 CLE low", logCle[lb], 0);
    end

    // R3: data input from each buffer
    for (int b = 0; b < NB; b++) begin
      for (int k = 0; k < MB; k++) hwrite(mainAddr(b, k), (k * 7 + 16'h31 + b * 64) & 255);
      for (int j = 0; j < SB; j++) hwrite(spareAddr(b, j), (j * 11 + 16'hA0 + b * 5) & 255);
      hwrite(RBASE + 2, b);
      launch(6'b000100);
      waitIdle();
      chk("R3 pulse count", logCount - lb, PB);
      for (int k = 0; k < PB; k++) begin
        int exp;
        exp = (k < MB) ? ((k * 7 + 16'h31 + b * 64) & 255) : (((k - MB) * 11 + 16'hA0 + b * 5) & 255);
        chk("R3 data byte", logData[lb + k], exp);
        chk("R3 CLE/ALE low", logCle[lb + k] + logAle[lb + k], 0);
      end
      chk("R12 WE low total", weLow - wb, PB * TL);
      chk("R12 CE low total", ceLow - cb, PB * (TL + TH) + 1);
    end

    // R4: page output into each buffer
    for (int b = 0; b < NB; b++) begin
      seed = seeds[b];
      hwrite(RBASE + 2, b);
      launch(6'b001000);
      waitIdle();
      chk("R4 no WE pulse", logCount - lb, 0);
      for (int k = 0; k < MB; k++) begin hread(mainAddr(b, k), v); chk("R4 main byte", v, pat(seeds[b], k)); end
      for (int j = 0; j < SB; j++) begin hread(spareAddr(b, j), v); chk("R4 spare byte", v, pat(seeds[b], MB + j)); end
    end
    for (int k = 0; k < MB; k++) begin hread(mainAddr(0, k), v); chk("R4 other buffer kept", v, pat(seeds[0], k)); end
    for (int j = 0; j < SB; j++) begin hread(spareAddr(0, j), v); chk("R4 other spare kept", v, pat(seeds[0], MB + j)); end

    // R5: read ID into buffer 1
    seed = 8'h77;
    hwrite(RBASE + 2, 1);
    launch(6'b010000);
    waitIdle();
    for (int k = 0; k < MB; k++) begin
      hread(mainAddr(1, k), v);
      chk("R5 id area", v, (k < IDB) ? pat(8'h77, k) : pat(seeds[1], k));
    end

    // R6: status into buffer 0
    seed = 8'hC3;
    hwrite(RBASE + 2, 0);
    launch(6'b100000);
    waitIdle();
    hread(mainAddr(0, 0), v); chk("R6 status byte", v, 8'hC3);
    hread(mainAddr(0, 1), v); chk("R6 next byte kept", v, pat(seeds[0], 1));

    // R7 / R8: done flag and interrupt
    hread(RBASE + 4, v); chk("R7 done set", (v >> 15) & 1, 1);
    chk("R8 irq when done", int'(irq), 1);
    hwrite(RBASE + 3, 16'h0010);
    chk("R8 irq masked", int'(irq), 0);
    hread(RBASE + 4, v); chk("R8 done still set under mask", (v >> 15) & 1, 1);
    hwrite(RBASE + 3, 0);
    chk("R8 irq unmasked", int'(irq), 1);
    hwrite(RBASE + 4, 16'h8000);
    hread(RBASE + 4, v); chk("R7 write 1 keeps done", (v >> 15) & 1, 1);
    hwrite(RBASE + 4, 0);
    hread(RBASE + 4, v); chk("R7 write 0 clears done", (v >> 15) & 1, 0);
    chk("R8 irq low after clear", int'(irq), 0);

    // R9: busy readback and trigger while busy
    hwrite(RBASE + 0, 8'hEE);
    launch(6'b000100);
    hwrite(RBASE + 4, 6'b000001);
    hread(RBASE + 5, v); chk("R9 busy bit", v & 1, 1);
    hread(RBASE + 4, v); chk("R9 active selection", v & 63, 6'b000100);
    waitIdle();
    chk("R9 no extra pulse", logCount - lb, PB);
    begin
      int cles = 0;
      for (int k = 0; k < PB; k++) cles += logCle[lb + k];
      chk("R9 no command cycle", cles, 0);
    end

    // R13: invalid control words
    launch(6'b000011);
    repeat (10) @(negedge clk);
    hread(RBASE + 5, v); chk("R13 two bits not busy", v & 1, 0);
    chk("R13 two bits no pulse", logCount - lb, 0);
    launch(6'b011000);
    repeat (10) @(negedge clk);
    chk("R13 field 011 no CE", ceLow - cb, 0);

    // R10: wait for ready
    nandRdy = 1'b0;
    launch(6'b000001);
    repeat (20) @(negedge clk);
    hread(RBASE + 4, v); chk("R10 no done while not ready", (v >> 15) & 1, 0);
    hread(RBASE + 5, v); chk("R10 still busy", v & 1, 1);
    nandRdy = 1'b1;
    waitIdle();
    hread(RBASE + 4, v); chk("R10 done after ready", (v >> 15) & 1, 1);
    hread(RBASE + 5, v); chk("R10 no error", (v >> 1) & 1, 0);

    // R11: timeout
    hwrite(RBASE + 6, 5);
    nandRdy = 1'b0;
    launch(6'b000010);
    repeat (30) @(negedge clk);
    hread(RBASE + 5, v); chk("R11 timeout error and idle", v & 3, 2);
    hread(RBASE + 4, v); chk("R11 done on timeout", (v >> 15) & 1, 1);
    nandRdy = 1'b1;
    launch(6'b000001);
    waitIdle();
    hread(RBASE + 5, v); chk("R11 error cleared", (v >> 1) & 1, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule